// File: doc/BRIEF.md
# ADC Bring-up Sequencer

This block brings a multichannel sigma-delta ADC from power-on into a known idle configuration after a system reset and a start request. It takes the converter through a reset, either by pulsing a dedicated active-low reset output for a fixed number of converter clocks or, when the board has no such pin, by sending a reset opcode. It then waits a fixed settling time counted in converter clocks. Next it stops continuous data output, reads and validates the identity byte, and writes two configuration registers.

All converter traffic leaves as requests to a separate register access engine. That engine serialises each request and returns a one-cycle completion pulse. Each request is a single-cycle strobe carrying an operation code, an opcode or register address, and a data byte. The sequencer never issues a request while an earlier one is still outstanding.

When the identity byte names one of the two supported families, the block reports the channel count and which family it found, and raises a done flag after the final write. An unknown identity raises a sticky error flag and halts the sequence. After the sequence ends, further start requests are ignored until the next system reset.

Top module: `adc_bringup_seq`

## Requirements
- R1: While and directly after system reset, `adcResetN` is 1, `reqValid` is 0, and `seqDone`, `errFlag`, `extFamily` and `chanCount` are all 0.
- R2: With `hasResetPin` = 1, `adcResetN` goes low on the cycle after the start request is taken. It stays low for exactly RST_HOLD_ADC × ADC_DIV clock cycles, which is 8 at the defaults, and no reset opcode is sent.
- R3: With `hasResetPin` = 0, `adcResetN` stays 1 and the first request is a command (reqOp = 0) with opcode 0x06.
- R4: The request after the reset has no earlier request. It is issued exactly SETTLE_ADC × ADC_DIV + 1 cycles (73 at the defaults) after either the last low cycle of `adcResetN` or the cycle in which the reset opcode's completion pulse arrives.
- R5: The first request after settling is a command (reqOp = 0) with opcode 0x11.
- R6: The next request is a read (reqOp = 1) of address 0x00. On a valid identity, `chanCount` becomes 4 + 2 × ID[2:0].
- R7: ID[7:3] = 5'b10010 is accepted as the base family (`extFamily` = 0), and ID[7:3] = 5'b11010 as the extended family (`extFamily` = 1).
- R8: Any other ID[7:3] sets `errFlag`. After that no further request is issued, `seqDone` stays 0 and `chanCount` stays 0.
- R9: After a valid identity, the next request is a write (reqOp = 2) to address 0x02 with data 0x55.
- R10: The last request is a write to address 0x03. Its data has bit 6 always set, bit 7 set when `useIntRef` = 1, and bit 5 set when both `useIntRef` and `avddHigh` are 1.
- R11: `reqValid` is a single-cycle strobe, and no new request is issued before the completion pulse for the previous one.
- R12: `seqDone` rises on the cycle after the completion pulse of the last write and stays high. A later `startReq` causes no request and no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| startReq | input | 1 | Starts the bring-up sequence; honoured once per system reset |
| hasResetPin | input | 1 | Strap: 1 when the converter's reset pin is wired |
| avddHigh | input | 1 | Strap: 1 when the analog supply is at least 4.4 V |
| useIntRef | input | 1 | Strap: 1 to select the converter's internal reference |
| adcResetN | output | 1 | Active-low reset to the converter |
| reqValid | output | 1 | One-cycle request strobe to the register engine |
| reqOp | output | 2 | 0 command, 1 register read, 2 register write |
| reqAddr | output | 8 | Command opcode or register address |
| reqData | output | 8 | Write data |
| engDone | input | 1 | One-cycle completion pulse from the register engine |
| engRdData | input | 8 | Read data, valid with engDone |
| chanCount | output | 5 | Detected channel count, 0 until a valid identity |
| extFamily | output | 1 | 1 when the extended family was found |
| errFlag | output | 1 | Sticky: unknown identity |
| seqDone | output | 1 | Sticky: sequence finished |

## Verification
The reset pulse begins on the cycle after the start strobe is registered and lasts exactly 8 cycles. The first request after reset settles 73 cycles after the last low cycle of the pin or after the cycle carrying the reset opcode's completion. `seqDone` follows the final completion pulse by one cycle. The bench samples on the falling edge and logs each request with its cycle number, so those distances are compared exactly rather than bounded. The engine model answers each request after a random delay of 1 to 4 cycles, which moves every later timestamp, so the checks measure each distance from its own triggering event instead of from the start. Identity bytes, straps and the reset path are drawn at random alongside directed bad-identity and channel-code extremes, and expected request lists, channel counts and configuration bytes are produced by bench functions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } reqOpT;

  typedef enum logic [2:0] {
    STEP_RST,
    STEP_HALTSTREAM,
    STEP_RDID,
    STEP_CFGA,
    STEP_CFGB
  } stepT;

  // control -> datapath strobes
  typedef struct packed {
    logic loadHold;
    logic loadSettle;
    logic tick;
    logic captureId;
    logic acceptId;
    logic markDone;
    logic markErr;
    stepT step;
  } ctlStrobesT;

  localparam logic [7:0] OPC_RESET      = 8'h06;
  localparam logic [7:0] OPC_HALTSTREAM = 8'h11;
  localparam logic [7:0] ADDR_ID        = 8'h00;
  localparam logic [7:0] ADDR_CFGA      = 8'h02;
  localparam logic [7:0] ADDR_CFGB      = 8'h03;
  localparam logic [7:0] CFGA_VALUE     = 8'h55;
  localparam logic [4:0] FAM_BASE       = 5'b10010;
  localparam logic [4:0] FAM_EXT        = 5'b11010;

endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       hasResetPin,
  input  logic       engDone,
  input  logic       timerZero,
  input  logic       familyOk,
  output ctlStrobesT ctl,
  output logic       reqValid,
  output logic       holdActive
);

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_SETTLE, S_ISSUE, S_ACK, S_CHECK, S_FAULT, S_FIN
  } stateT;

  stateT stateQ, stateD;
  stepT  stepQ, stepD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stepQ  <= STEP_RST;
    end else begin
      stateQ <= stateD;
      stepQ  <= stepD;
    end
  end

  always_comb begin
    stateD         = stateQ;
    stepD          = stepQ;
    ctl            = '0;
    ctl.step       = stepQ;
    unique case (stateQ)
      S_IDLE: if (startReq) begin
        if (hasResetPin) begin
          stateD       = S_HOLD;
          ctl.loadHold = 1'b1;
        end else begin
          stateD = S_ISSUE;
          stepD  = STEP_RST;
        end
      end
      S_HOLD: begin
        ctl.tick = 1'b1;
        if (timerZero) begin
          stateD         = S_SETTLE;
          ctl.loadSettle = 1'b1;
        end
      end
      S_SETTLE: begin
        ctl.tick = 1'b1;
        if (timerZero) begin
          stateD = S_ISSUE;
          stepD  = STEP_HALTSTREAM;
        end
      end
      S_ISSUE: stateD = S_ACK;
      S_ACK: if (engDone) begin
        unique case (stepQ)
          STEP_RST: begin
            stateD         = S_SETTLE;
            ctl.loadSettle = 1'b1;
          end
          STEP_HALTSTREAM: begin
            stateD = S_ISSUE;
            stepD  = STEP_RDID;
          end
          STEP_RDID: begin
            stateD        = S_CHECK;
            ctl.captureId = 1'b1;
          end
          STEP_CFGA: begin
            stateD = S_ISSUE;
            stepD  = STEP_CFGB;
          end
          default: begin
            stateD       = S_FIN;
            ctl.markDone = 1'b1;
          end
        endcase
      end
      S_CHECK: begin
        if (familyOk) begin
          stateD       = S_ISSUE;
          stepD        = STEP_CFGA;
          ctl.acceptId = 1'b1;
        end else begin
          stateD      = S_FAULT;
          ctl.markErr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign reqValid   = (stateQ == S_ISSUE);
  assign holdActive = (stateQ == S_HOLD);

  // R11: a request is never followed directly by another strobe
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R2: the reset pin path is entered only with the strap present
  a_r2_hold_needs_pin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> hasResetPin);

  // R12: once finished, the sequencer never issues again
  a_r12_fin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_FIN) |=> (stateQ == S_FIN) && !reqValid);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int HOLD_CYC   = 8,
  parameter int SETTLE_CYC = 72
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobesT ctl,
  input  logic [7:0] engRdData,
  input  logic       avddHigh,
  input  logic       useIntRef,
  output logic       timerZero,
  output logic       familyOk,
  output logic [1:0] reqOp,
  output logic [7:0] reqAddr,
  output logic [7:0] reqData,
  output logic [4:0] chanCount,
  output logic       extFamily,
  output logic       errFlag,
  output logic       seqDone
);

  localparam int MAX_CYC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] HOLD_LOAD   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYC - 1);

  logic [TMR_W-1:0] timerQ;
  logic [7:0]       idQ;

  always_ff @(posedge clk) begin
    if (!rstN)               timerQ <= '0;
    else if (ctl.loadHold)   timerQ <= HOLD_LOAD;
    else if (ctl.loadSettle) timerQ <= SETTLE_LOAD;
    else if (ctl.tick && timerQ != '0) timerQ <= timerQ - 1'b1;
  end

  assign timerZero = (timerQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ       <= '0;
      chanCount <= '0;
      extFamily <= 1'b0;
      errFlag   <= 1'b0;
      seqDone   <= 1'b0;
    end else begin
      if (ctl.captureId) idQ <= engRdData;
      if (ctl.acceptId) begin
        chanCount <= 5'd4 + {1'b0, idQ[2:0], 1'b0};
        extFamily <= (idQ[7:3] == FAM_EXT);
      end
      if (ctl.markErr)  errFlag <= 1'b1;
      if (ctl.markDone) seqDone <= 1'b1;
    end
  end

  assign familyOk = (idQ[7:3] == FAM_BASE) || (idQ[7:3] == FAM_EXT);

  always_comb begin
    reqOp   = OP_CMD;
    reqAddr = OPC_RESET;
    reqData = 8'h00;
    unique case (ctl.step)
      STEP_RST:        reqAddr = OPC_RESET;
      STEP_HALTSTREAM: reqAddr = OPC_HALTSTREAM;
      STEP_RDID: begin
        reqOp   = OP_READ;
        reqAddr = ADDR_ID;
      end
      STEP_CFGA: begin
        reqOp   = OP_WRITE;
        reqAddr = ADDR_CFGA;
        reqData = CFGA_VALUE;
      end
      default: begin
        reqOp   = OP_WRITE;
        reqAddr = ADDR_CFGB;
        reqData = {useIntRef, 1'b1, useIntRef & avddHigh, 5'b00000};
      end
    endcase
  end

  // R8: error and done are mutually exclusive
  a_r8_err_excludes_done: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && seqDone));

  // R8: error is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R12: done is sticky
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> seqDone);

  // R6: a reported channel count lies in the legal range and is even
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (chanCount >= 5'd4) && (chanCount <= 5'd18) && !chanCount[0]);

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adc_seq_pkg::*;
#(
  parameter int ADC_DIV      = 4,
  parameter int RST_HOLD_ADC = 2,
  parameter int SETTLE_ADC   = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       hasResetPin,
  input  logic       avddHigh,
  input  logic       useIntRef,
  output logic       adcResetN,
  output logic       reqValid,
  output logic [1:0] reqOp,
  output logic [7:0] reqAddr,
  output logic [7:0] reqData,
  input  logic       engDone,
  input  logic [7:0] engRdData,
  output logic [4:0] chanCount,
  output logic       extFamily,
  output logic       errFlag,
  output logic       seqDone
);

  localparam int HOLD_CYC   = RST_HOLD_ADC * ADC_DIV;
  localparam int SETTLE_CYC = SETTLE_ADC * ADC_DIV;

  ctlStrobesT ctl;
  logic       timerZero;
  logic       familyOk;
  logic       holdActive;

  adc_seq_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .hasResetPin(hasResetPin),
    .engDone    (engDone),
    .timerZero  (timerZero),
    .familyOk   (familyOk),
    .ctl        (ctl),
    .reqValid   (reqValid),
    .holdActive (holdActive)
  );

  adc_seq_dp #(
    .HOLD_CYC  (HOLD_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .engRdData (engRdData),
    .avddHigh  (avddHigh),
    .useIntRef (useIntRef),
    .timerZero (timerZero),
    .familyOk  (familyOk),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .chanCount (chanCount),
    .extFamily (extFamily),
    .errFlag   (errFlag),
    .seqDone   (seqDone)
  );

  assign adcResetN = !holdActive;

  // R3: the reset pin never moves when the strap says it is absent
  a_r3_pin_idle_without_strap: assert property (@(posedge clk) disable iff (!rstN)
    !hasResetPin |-> adcResetN);

endmodule

// File: tb/test_adc_bringup_seq.sv
module test_adc_bringup_seq;

  localparam int H = 8;
  localparam int S = 72;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic hasResetPin = 1'b0;
  logic avddHigh = 1'b0;
  logic useIntRef = 1'b0;
  logic engDone = 1'b0;
  logic [7:0] engRdData = 8'h00;
  logic adcResetN, reqValid, extFamily, errFlag, seqDone;
  logic [1:0] reqOp;
  logic [7:0] reqAddr, reqData;
  logic [4:0] chanCount;

  always #2.5 clk = ~clk;

  adc_bringup_seq i_adc_bringup_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .hasResetPin(hasResetPin),
    .avddHigh(avddHigh), .useIntRef(useIntRef), .adcResetN(adcResetN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .engDone(engDone), .engRdData(engRdData), .chanCount(chanCount),
    .extFamily(extFamily), .errFlag(errFlag), .seqDone(seqDone)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // engine model and monitor state
  logic [7:0] idVal = 8'h00;
  int n = 0;
  int lowCnt = 0;
  int lastLow = -1;
  int overlap = 0;
  bit pending = 0;
  int delay = 0;
  int firstDone = -1;
  logic [1:0] logOp [16];
  logic [7:0] logAddr [16];
  logic [7:0] logData [16];
  int reqCyc [16];
  int doneCyc [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    engDone <= 1'b0;
    if (rstN) begin
      if (!adcResetN) begin
        lowCnt = lowCnt + 1;
        lastLow = cyc;
      end
      if (seqDone && firstDone < 0) firstDone = cyc;
      if (reqValid) begin
        if (pending) overlap = overlap + 1;
        if (n < 16) begin
          logOp[n] = reqOp; logAddr[n] = reqAddr; logData[n] = reqData;
          reqCyc[n] = cyc;
        end
        n = n + 1;
        pending = 1;
        delay = 1 + int'($urandom_range(3, 0));
      end else if (pending) begin
        delay = delay - 1;
        if (delay == 0) begin
          engDone <= 1'b1;
          engRdData <= idVal;
          if (n >= 1 && n <= 16) doneCyc[n-1] = cyc;
          pending = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic bit famOk(input logic [7:0] id);
    return (id[7:3] == 5'b10010) || (id[7:3] == 5'b11010);
  endfunction

  function automatic logic [7:0] cfgbExp(input bit iref, input bit avdd);
    return {iref, 1'b1, iref & avdd, 5'b0};
  endfunction

  task automatic runTrial(input bit pin, input bit avdd, input bit iref,
                          input logic [7:0] id, input bit tryRestart);
    int base;
    int expN;
    int snapN;
    int snapLow;
    hasResetPin = pin; avddHigh = avdd; useIntRef = iref; idVal = id;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    n = 0; lowCnt = 0; lastLow = -1; overlap = 0; pending = 0; firstDone = -1;
    // R1: reset state
    chk(adcResetN === 1'b1 && reqValid === 1'b0, "R1 pins", {adcResetN, reqValid}, 2);
    chk(seqDone === 0 && errFlag === 0 && chanCount === 0 && extFamily === 0,
        "R1 status", {seqDone, errFlag, extFamily, chanCount}, 0);
    @(posedge clk); rstN <= 1'b1;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int k = 0; k < 3000 && !seqDone && !errFlag; k++) @(negedge clk);
    repeat (20) @(negedge clk);

    base = pin ? 0 : 1;
    expN = famOk(id) ? base + 4 : base + 2;
    chk(n == expN, "R8/R12 request count", n, expN);
    chk(overlap == 0, "R11 overlap", overlap, 0);
    if (pin) begin
      chk(lowCnt == H, "R2 hold length", lowCnt, H);
      chk(reqCyc[0] - lastLow == S + 1, "R4 settle after pin", reqCyc[0] - lastLow, S + 1);
    end else begin
      chk(lowCnt == 0, "R3 pin idle", lowCnt, 0);
      chk(logOp[0] == 2'd0 && logAddr[0] == 8'h06, "R3 reset opcode",
          {logOp[0], logAddr[0]}, 8'h06);
      chk(reqCyc[1] - doneCyc[0] == S + 1, "R4 settle after opcode",
          reqCyc[1] - doneCyc[0], S + 1);
    end
    chk(logOp[base] == 2'd0 && logAddr[base] == 8'h11, "R5 stop streaming",
        {logOp[base], logAddr[base]}, 8'h11);
    chk(logOp[base+1] == 2'd1 && logAddr[base+1] == 8'h00, "R6 id read",
        {logOp[base+1], logAddr[base+1]}, 10'h100);
    if (famOk(id)) begin
      chk(chanCount == 5'(4 + 2 * id[2:0]), "R6 channel count", chanCount, 4 + 2 * id[2:0]);
      chk(extFamily == (id[7:3] == 5'b11010), "R7 family", extFamily, (id[7:3] == 5'b11010));
      chk(errFlag == 0, "R7 no error", errFlag, 0);
      chk(logOp[base+2] == 2'd2 && logAddr[base+2] == 8'h02 && logData[base+2] == 8'h55,
          "R9 cfg A write", {logOp[base+2], logAddr[base+2], logData[base+2]}, 18'h20255);
      chk(logOp[base+3] == 2'd2 && logAddr[base+3] == 8'h03 &&
          logData[base+3] == cfgbExp(iref, avdd), "R10 cfg B write",
          logData[base+3], cfgbExp(iref, avdd));
      chk(firstDone - doneCyc[base+3] == 1, "R12 done timing",
          firstDone - doneCyc[base+3], 1);
    end else begin
      chk(errFlag == 1 && seqDone == 0, "R8 error flag", {errFlag, seqDone}, 2);
      chk(chanCount == 0, "R8 count held", chanCount, 0);
    end
    if (tryRestart) begin
      snapN = n; snapLow = lowCnt;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      repeat (120) @(negedge clk);
      chk(n == snapN && lowCnt == snapLow, "R12 restart ignored",
          n - snapN + lowCnt - snapLow, 0);
      chk(seqDone == famOk(id), "R12 done held", seqDone, famOk(id));
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7331);
    // directed corners
    runTrial(1, 1, 1, 8'h96, 1);   // base family, 16 channels, pin path
    runTrial(0, 1, 1, 8'hD7, 1);   // extended, 18 channels, opcode path
    runTrial(1, 0, 0, 8'h90, 0);   // smallest count, external reference
    runTrial(0, 0, 1, 8'hD0, 0);   // internal ref, low supply
    runTrial(1, 1, 1, 8'h55, 1);   // bad identity
    runTrial(0, 1, 0, 8'h98, 0);   // neighbour of a valid family
    // random mix
    for (int t = 0; t < 14; t++) begin
      logic [7:0] id;
      int pick;
      pick = int'($urandom_range(2, 0));
      id = 8'($urandom);
      if (pick == 0) id[7:3] = 5'b10010;
      else if (pick == 1) id[7:3] = 5'b11010;
      runTrial(1'($urandom), 1'($urandom), 1'($urandom), id, 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule